// File: doc/BRIEF.md
# Reset Cause Recorder and Release Sequencer

This block gathers every reset request in the chip into one system reset and keeps a sticky record of which event caused it. The block receives single-cycle event pulses for power-on, brown-out, the external reset pin, the software reset instruction, watchdog expiry, trap conflict and illegal opcode. It also receives pulses for entry into the two power-save states, sleep and idle. These two record a flag but do not request a reset. Software can read the flag register and write it at any time to set or clear any implemented bit.

After any reset request the system reset output is held for a power-on delay, followed by a power-up timer delay. Both lengths are parameters. A request that arrives while either delay is running starts the sequence again. The oscillator start-up and PLL lock run alongside the delays, so code may run only once the reset is released and both of those are ready. On each request the block also picks the clock source for the next run. A power-on reset takes the configured source, and other reset types keep the source currently in use. If clock switching is disabled, every reset takes the configured source.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A trap conflict pulse sets flag bit 15 and an illegal opcode pulse sets flag bit 14, one cycle after the pulse.
- R2: An external pin reset sets bit 7, a software reset instruction sets bit 6 and a watchdog expiry sets bit 4, one cycle after the pulse.
- R3: A sleep pulse sets bit 3 and clears bit 2. An idle pulse sets bit 2 and clears bit 3.
- R4: A power-on pulse sets bits 1 and 0. A brown-out pulse sets bit 1 and leaves bit 0 unchanged.
- R5: A power-on or brown-out pulse clears bits 15, 14, 7, 6, 4, 3 and 2 unless the same cycle also sets them.
- R6: A register write with the write strobe loads every implemented bit (15, 14, 7, 6, 4, 3, 2, 1, 0) from the write data. Bits 13..8 and bit 5 always read 0.
- R7: If a hardware event and a software write arrive in the same cycle, the bit that the event sets ends up 1.
- R8: `sys_rst` is 1 from the cycle after any reset request. It falls exactly POR_DLY+PWRT_DLY cycles after the last request. A request made during the delays restarts the count.
- R9: `cpu_run` is 1 only when `sys_rst` is 0 and both `osc_ready` and `pll_locked` are 1.
- R10: On a reset request, `boot_osc` loads `cfg_osc` one cycle later if the request includes power-on or `clksw_en` is 0. Otherwise it loads `cur_osc`.
- R11: While `rst_n` is low, `flags` is 0, `sys_rst` is 1, `cpu_run` is 0 and `boot_osc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low initialisation |
| por_evt | input | 1 | Power-on event pulse |
| bor_evt | input | 1 | Brown-out event pulse |
| pin_rst_evt | input | 1 | External reset pin pulse |
| sw_rst_evt | input | 1 | Software reset instruction pulse |
| wdt_evt | input | 1 | Watchdog expiry pulse |
| trap_evt | input | 1 | Trap conflict pulse |
| illop_evt | input | 1 | Illegal opcode or uninitialised register access pulse |
| sleep_evt | input | 1 | Sleep entry pulse |
| idle_evt | input | 1 | Idle entry pulse |
| flag_we | input | 1 | Software write strobe for the flag register |
| flag_wdata | input | 16 | Software write data |
| flags | output | 16 | Sticky cause flag register |
| clksw_en | input | 1 | Clock switching enabled |
| cfg_osc | input | 3 | Configured oscillator selection |
| cur_osc | input | 3 | Oscillator currently in use |
| osc_ready | input | 1 | Oscillator start-up timer done |
| pll_locked | input | 1 | PLL lock wait done |
| sys_rst | output | 1 | System reset, active high |
| cpu_run | output | 1 | Code execution permitted |
| boot_osc | output | 3 | Clock source chosen for the next run |

## Verification
Flag updates and the `boot_osc` choice appear one clock after the event or write. `sys_rst` rises one clock after a request and falls POR_DLY+PWRT_DLY clocks after the last request. `cpu_run` follows the ready inputs in the same cycle. The bench drives inputs on the falling edge. It advances a behavioural model at each rising edge and compares all outputs 3 ns after that edge, when every register has settled. Directed checks on the falling edge compare hand-computed constants for each scenario, including a restart in the middle of the delay and a write that collides with an event.

// File: rtl/rc_pkg.sv
// Package: shared bit positions, flag mask and sequencer state for the reset
// cause controller. Assumes a 16-bit flag register.
package rc_pkg;
    localparam int FLAG_W  = 16;
    localparam int B_TRAP  = 15;
    localparam int B_ILLOP = 14;
    localparam int B_PIN   = 7;
    localparam int B_SWR   = 6;
    localparam int B_WDT   = 4;
    localparam int B_SLEEP = 3;
    localparam int B_IDLE  = 2;
    localparam int B_BOR   = 1;
    localparam int B_POR   = 0;

    localparam logic [FLAG_W-1:0] FLAG_MASK =
        (FLAG_W'(1) << B_TRAP) | (FLAG_W'(1) << B_ILLOP) | (FLAG_W'(1) << B_PIN) |
        (FLAG_W'(1) << B_SWR)  | (FLAG_W'(1) << B_WDT)   | (FLAG_W'(1) << B_SLEEP) |
        (FLAG_W'(1) << B_IDLE) | (FLAG_W'(1) << B_BOR)   | (FLAG_W'(1) << B_POR);

    // Bits wiped by a power-on or brown-out event
    localparam logic [FLAG_W-1:0] SUPPLY_CLR =
        (FLAG_W'(1) << B_TRAP) | (FLAG_W'(1) << B_ILLOP) | (FLAG_W'(1) << B_PIN) |
        (FLAG_W'(1) << B_SWR)  | (FLAG_W'(1) << B_WDT)   | (FLAG_W'(1) << B_SLEEP) |
        (FLAG_W'(1) << B_IDLE);

    typedef struct packed {
        logic trap;
        logic illop;
        logic pin;
        logic swr;
        logic wdt;
        logic sleep;
        logic idle;
        logic bor;
        logic por;
    } rc_events_t;

    typedef enum logic [1:0] {
        SEQ_PORD = 2'd0,
        SEQ_PWRT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rc_flags.sv
// Sticky cause flag register. A software write loads the implemented bits.
// Supply events and the power-save pulses then clear their bits, and hardware
// events then set theirs, so a hardware set beats a same-cycle write.
// Assumes the event inputs are single-cycle pulses.
module rc_flags
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rc_events_t        ev,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags_q
);
    logic [FLAG_W-1:0] base;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] nxt;

    // Build the per-bit clear and set vectors from the events
    always_comb begin
        clr_vec = '0;
        set_vec = '0;
        if (ev.por || ev.bor) clr_vec = clr_vec | SUPPLY_CLR;
        clr_vec[B_IDLE]  = clr_vec[B_IDLE]  | ev.sleep;
        clr_vec[B_SLEEP] = clr_vec[B_SLEEP] | ev.idle;
        set_vec[B_TRAP]  = ev.trap;
        set_vec[B_ILLOP] = ev.illop;
        set_vec[B_PIN]   = ev.pin;
        set_vec[B_SWR]   = ev.swr;
        set_vec[B_WDT]   = ev.wdt;
        set_vec[B_SLEEP] = ev.sleep;
        set_vec[B_IDLE]  = ev.idle;
        set_vec[B_BOR]   = ev.bor | ev.por;
        set_vec[B_POR]   = ev.por;
    end

    // Next value: write (or hold), then clears, then sets, unused bits forced to 0
    always_comb begin
        base = wr_en ? wr_data : flags_q;
        nxt  = ((base & ~clr_vec) | set_vec) & FLAG_MASK;
    end

    // Flag register
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= nxt;
    end
endmodule

// File: rtl/rc_seq.sv
// Release sequencer: after a reset request it counts POR_DLY cycles and then
// PWRT_DLY cycles before releasing the system reset. A new request restarts
// the count. Execution is gated by the oscillator and PLL ready inputs.
// Assumes both delays are at least 1.
module rc_seq
    import rc_pkg::*;
#(
    parameter int unsigned POR_DLY  = 16,
    parameter int unsigned PWRT_DLY = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic osc_ready,
    input  logic pll_locked,
    output logic sys_rst,
    output logic cpu_run
);
    localparam int unsigned MAX_DLY = (POR_DLY > PWRT_DLY) ? POR_DLY : PWRT_DLY;
    localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_DLY - 1);
    localparam logic [CNT_W-1:0] PWRT_LAST = CNT_W'(PWRT_DLY - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Delay state machine with restart on any request
    always_ff @(posedge clk) begin
        if (!rst_n || req) begin
            state <= SEQ_PORD;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_PORD: begin
                    if (cnt == POR_LAST) begin
                        state <= SEQ_PWRT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_PWRT: begin
                    if (cnt == PWRT_LAST) begin
                        state <= SEQ_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SEQ_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Outputs: reset held until the run state, execution also needs clocks ready
    always_comb begin
        sys_rst = (state != SEQ_RUN);
        cpu_run = !sys_rst && osc_ready && pll_locked;
    end
endmodule

// File: rtl/rc_clksel.sv
// Post-reset clock choice: on a request, a power-on (or disabled clock
// switching) takes the configured source and any other reset keeps the
// current one. Assumes req is high whenever por is high.
module rc_clksel #(
    parameter int unsigned OSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             por,
    input  logic             clksw_en,
    input  logic [OSC_W-1:0] cfg_osc,
    input  logic [OSC_W-1:0] cur_osc,
    output logic [OSC_W-1:0] boot_osc
);
    // Capture the chosen source on every request
    always_ff @(posedge clk) begin
        if (!rst_n)   boot_osc <= '0;
        else if (req) boot_osc <= (por || !clksw_en) ? cfg_osc : cur_osc;
    end
endmodule

// File: rtl/rst_cause_ctrl.sv
// Reset cause and sequencing controller top. Packs the event pulses, forms
// the combined reset request and joins the flag register, the release
// sequencer and the clock chooser. Assumes all events are synchronous pulses.
module rst_cause_ctrl
    import rc_pkg::*;
#(
    parameter int unsigned POR_DLY  = 16,
    parameter int unsigned PWRT_DLY = 24,
    parameter int unsigned OSC_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_evt,
    input  logic              bor_evt,
    input  logic              pin_rst_evt,
    input  logic              sw_rst_evt,
    input  logic              wdt_evt,
    input  logic              trap_evt,
    input  logic              illop_evt,
    input  logic              sleep_evt,
    input  logic              idle_evt,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic [FLAG_W-1:0] flags,
    input  logic              clksw_en,
    input  logic [OSC_W-1:0]  cfg_osc,
    input  logic [OSC_W-1:0]  cur_osc,
    input  logic              osc_ready,
    input  logic              pll_locked,
    output logic              sys_rst,
    output logic              cpu_run,
    output logic [OSC_W-1:0]  boot_osc
);
    rc_events_t ev;
    logic       req_any;

    // Pack the events and combine the ones that request a reset
    always_comb begin
        ev.trap  = trap_evt;
        ev.illop = illop_evt;
        ev.pin   = pin_rst_evt;
        ev.swr   = sw_rst_evt;
        ev.wdt   = wdt_evt;
        ev.sleep = sleep_evt;
        ev.idle  = idle_evt;
        ev.bor   = bor_evt;
        ev.por   = por_evt;
        req_any  = por_evt | bor_evt | pin_rst_evt | sw_rst_evt |
                   wdt_evt | trap_evt | illop_evt;
    end

    rc_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .wr_en   (flag_we),
        .wr_data (flag_wdata),
        .flags_q (flags)
    );

    rc_seq #(
        .POR_DLY  (POR_DLY),
        .PWRT_DLY (PWRT_DLY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_any),
        .osc_ready  (osc_ready),
        .pll_locked (pll_locked),
        .sys_rst    (sys_rst),
        .cpu_run    (cpu_run)
    );

    rc_clksel #(
        .OSC_W (OSC_W)
    ) u_clksel (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_any),
        .por      (por_evt),
        .clksw_en (clksw_en),
        .cfg_osc  (cfg_osc),
        .cur_osc  (cur_osc),
        .boot_osc (boot_osc)
    );
endmodule

// File: rtl/rc_chk.sv
// Property checker for the reset cause controller, bound to the top. Keeps
// its own count of reset-held cycles to check the release point.
module rc_chk
    import rc_pkg::*;
#(
    parameter int unsigned POR_DLY  = 16,
    parameter int unsigned PWRT_DLY = 24,
    parameter int unsigned OSC_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_evt,
    input logic              bor_evt,
    input logic              pin_rst_evt,
    input logic              sw_rst_evt,
    input logic              wdt_evt,
    input logic              trap_evt,
    input logic              illop_evt,
    input logic              sleep_evt,
    input logic              idle_evt,
    input logic              flag_we,
    input logic [FLAG_W-1:0] flags,
    input logic [OSC_W-1:0]  cfg_osc,
    input logic              osc_ready,
    input logic              pll_locked,
    input logic              sys_rst,
    input logic              cpu_run,
    input logic [OSC_W-1:0]  boot_osc
);
    localparam int unsigned TOTAL = POR_DLY + PWRT_DLY;

    logic        chk_req;
    int unsigned held;

    assign chk_req = por_evt | bor_evt | pin_rst_evt | sw_rst_evt |
                     wdt_evt | trap_evt | illop_evt;

    // Count clocks with reset held since the last request
    always_ff @(posedge clk) begin
        if (!rst_n || chk_req)           held <= 0;
        else if (sys_rst && held < TOTAL) held <= held + 1;
    end

    p_trap_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_evt |=> flags[B_TRAP]);
    p_wdt_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_evt |=> flags[B_WDT]);
    p_sleep_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_evt && !idle_evt) |=> (flags[B_SLEEP] && !flags[B_IDLE]));
    p_por_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> (flags[B_POR] && flags[B_BOR]));
    p_bor_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bor_evt && !por_evt && !trap_evt && !illop_evt && !pin_rst_evt &&
         !sw_rst_evt && !wdt_evt && !sleep_evt && !idle_evt)
        |=> ((flags & SUPPLY_CLR) == '0));
    p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~FLAG_MASK) == '0);
    p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && pin_rst_evt) |=> flags[B_PIN]);
    p_req_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> sys_rst);
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (held == TOTAL));
    p_run_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> (!sys_rst && osc_ready && pll_locked));
    p_por_osc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> (boot_osc == $past(cfg_osc)));
endmodule

bind rst_cause_ctrl rc_chk #(
    .POR_DLY  (POR_DLY),
    .PWRT_DLY (PWRT_DLY),
    .OSC_W    (OSC_W)
) u_rc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_evt     (por_evt),
    .bor_evt     (bor_evt),
    .pin_rst_evt (pin_rst_evt),
    .sw_rst_evt  (sw_rst_evt),
    .wdt_evt     (wdt_evt),
    .trap_evt    (trap_evt),
    .illop_evt   (illop_evt),
    .sleep_evt   (sleep_evt),
    .idle_evt    (idle_evt),
    .flag_we     (flag_we),
    .flags       (flags),
    .cfg_osc     (cfg_osc),
    .osc_ready   (osc_ready),
    .pll_locked  (pll_locked),
    .sys_rst     (sys_rst),
    .cpu_run     (cpu_run),
    .boot_osc    (boot_osc)
);

// File: tb/tb_rst_cause_ctrl.sv
// Bench: behavioural model advanced on each rising edge and compared 3 ns
// later, plus directed checks against hand-computed constants.
module tb_rst_cause_ctrl;
    localparam int P = 4;
    localparam int T = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_evt = 0, bor_evt = 0, pin_rst_evt = 0, sw_rst_evt = 0, wdt_evt = 0;
    logic        trap_evt = 0, illop_evt = 0, sleep_evt = 0, idle_evt = 0;
    logic        flag_we = 0;
    logic [15:0] flag_wdata = '0;
    logic [15:0] flags;
    logic        clksw_en = 1'b1;
    logic [2:0]  cfg_osc = 3'd5, cur_osc = 3'd2;
    logic        osc_ready = 1'b1, pll_locked = 1'b1;
    logic        sys_rst, cpu_run;
    logic [2:0]  boot_osc;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit armed = 0;

    always #5 clk = ~clk;

    rst_cause_ctrl #(.POR_DLY(P), .PWRT_DLY(T), .OSC_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bor_evt(bor_evt),
        .pin_rst_evt(pin_rst_evt), .sw_rst_evt(sw_rst_evt), .wdt_evt(wdt_evt),
        .trap_evt(trap_evt), .illop_evt(illop_evt), .sleep_evt(sleep_evt),
        .idle_evt(idle_evt), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .flags(flags), .clksw_en(clksw_en), .cfg_osc(cfg_osc), .cur_osc(cur_osc),
        .osc_ready(osc_ready), .pll_locked(pll_locked), .sys_rst(sys_rst),
        .cpu_run(cpu_run), .boot_osc(boot_osc));

    // Reference model state
    logic [15:0] m_flags;
    int          m_left;
    logic [2:0]  m_boot;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each rising edge, written from the requirements
    always @(posedge clk) begin
        logic [15:0] f;
        bit req;
        req = por_evt | bor_evt | pin_rst_evt | sw_rst_evt | wdt_evt | trap_evt | illop_evt;
        if (!rst_n) begin
            m_flags = 16'h0; m_left = P + T; m_boot = 3'd0;
        end else begin
            f = flag_we ? flag_wdata : m_flags;
            if (por_evt || bor_evt) begin
                f[15] = 0; f[14] = 0; f[7] = 0; f[6] = 0; f[4] = 0; f[3] = 0; f[2] = 0;
            end
            if (sleep_evt) f[2] = 0;
            if (idle_evt)  f[3] = 0;
            if (trap_evt)  f[15] = 1;
            if (illop_evt) f[14] = 1;
            if (pin_rst_evt) f[7] = 1;
            if (sw_rst_evt)  f[6] = 1;
            if (wdt_evt)     f[4] = 1;
            if (sleep_evt)   f[3] = 1;
            if (idle_evt)    f[2] = 1;
            if (por_evt || bor_evt) f[1] = 1;
            if (por_evt)     f[0] = 1;
            f[13:8] = '0; f[5] = 0;
            m_flags = f;
            if (req) begin
                m_left = P + T;
                m_boot = (por_evt || !clksw_en) ? cfg_osc : cur_osc;
            end else if (m_left > 0) begin
                m_left = m_left - 1;
            end
        end
        armed = 1;
    end

    // Compare every output once registers have settled
    always @(posedge clk) begin
        #3;
        if (armed && !done) begin
            check(flags == m_flags, "R6 flags vs model", flags, m_flags);
            check(sys_rst == (m_left > 0), "R8 sys_rst vs model", sys_rst, m_left > 0);
            check(cpu_run == (m_left == 0 && osc_ready && pll_locked), "R9 cpu_run vs model",
                  cpu_run, (m_left == 0 && osc_ready && pll_locked));
            check(boot_osc == m_boot, "R10 boot_osc vs model", boot_osc, m_boot);
        end
    end

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: por_evt = 1;  1: bor_evt = 1;  2: pin_rst_evt = 1; 3: sw_rst_evt = 1;
            4: wdt_evt = 1;  5: trap_evt = 1; 6: illop_evt = 1;   7: sleep_evt = 1;
            default: idle_evt = 1;
        endcase
        @(negedge clk);
        {por_evt, bor_evt, pin_rst_evt, sw_rst_evt, wdt_evt, trap_evt, illop_evt,
         sleep_evt, idle_evt} = '0;
    endtask

    task automatic sw_write(input logic [15:0] d, input bit with_pin);
        @(negedge clk);
        flag_we = 1; flag_wdata = d; pin_rst_evt = with_pin;
        @(negedge clk);
        flag_we = 0; pin_rst_evt = 0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(flags == 16'h0, "R11 reset flags", flags, 0);
        check(sys_rst == 1'b1, "R11 reset sys_rst", sys_rst, 1);
        check(cpu_run == 1'b0, "R11 reset cpu_run", cpu_run, 0);
        check(boot_osc == 3'd0, "R11 reset boot_osc", boot_osc, 0);
        rst_n = 1;

        pulse(0);
        wait_n(12);
        check(flags == 16'h0003, "R4 power-on flags", flags, 16'h0003);
        check(boot_osc == 3'd5, "R10 power-on takes cfg", boot_osc, 5);
        check(sys_rst == 1'b0, "R8 released", sys_rst, 0);

        pulse(5); pulse(6);
        pulse(2); pulse(3); pulse(4);
        wait_n(12);
        check(flags == 16'hC0D3, "R1 R2 event flags", flags, 16'hC0D3);
        check(boot_osc == 3'd2, "R10 warm reset keeps current", boot_osc, 2);

        pulse(2);
        wait_n(4);
        pulse(4);
        wait_n(8);
        check(sys_rst == 1'b1, "R8 restart still held", sys_rst, 1);
        wait_n(2);
        check(sys_rst == 1'b0, "R8 release after restart", sys_rst, 0);

        pulse(7);
        check(flags[3:2] == 2'b10, "R3 sleep", flags[3:2], 2'b10);
        pulse(8);
        check(flags[3:2] == 2'b01, "R3 idle clears sleep", flags[3:2], 2'b01);

        sw_write(16'hFFFF, 0);
        check(flags == 16'hC0DF, "R6 write ones, unused zero", flags, 16'hC0DF);
        sw_write(16'h0000, 0);
        check(flags == 16'h0000, "R6 write zeros", flags, 0);
        pulse(1);
        wait_n(12);
        check(flags == 16'h0002, "R4 brown-out sets bit1 only", flags, 16'h0002);
        sw_write(16'hFFFF, 0);
        pulse(1);
        check(flags == 16'h0003, "R5 brown-out clears events", flags, 16'h0003);
        wait_n(12);

        sw_write(16'h0000, 1);
        check(flags == 16'h0080, "R7 event beats write", flags, 16'h0080);

        clksw_en = 0; cfg_osc = 3'd1; cur_osc = 3'd6;
        pulse(4);
        check(boot_osc == 3'd1, "R10 switching disabled", boot_osc, 1);
        wait_n(12);
        osc_ready = 0;
        @(negedge clk);
        check(cpu_run == 1'b0, "R9 oscillator not ready", cpu_run, 0);
        osc_ready = 1; pll_locked = 0;
        @(negedge clk);
        check(cpu_run == 1'b0, "R9 PLL not locked", cpu_run, 0);
        pll_locked = 1;
        @(negedge clk);
        check(cpu_run == 1'b1, "R9 running", cpu_run, 1);

        wait_n(2);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule